// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block turns a single asynchronous serial line into 8-bit characters. It is clocked by the system clock and paced by a one-cycle sample-enable tick that runs at sixteen times the bit rate. It finds the falling edge of a start bit and confirms it at mid-bit. It then takes every later bit at its centre sample. Each character is checked against its stop bit and, when enabled, against a parity bit.

The block has two formats. In plain mode, the bit after the data is either a parity bit or absent. In addressed mode, that position holds a marker bit that tags the character as a node address (1) or as payload (0). The receiver compares every address character with its own programmed address. When they match, it delivers the address and the payload characters that follow. While unaddressed, it drops payload characters silently. This lets several nodes share one line, and each host only sees traffic meant for it.

Good characters are placed in a holding register and a full flag is raised. Errors raise sticky flags instead. A one-cycle read strobe from the host clears the full flag and every error flag. Two interrupt request outputs follow the full flag and the error flags.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, `rx_full`, `err_frame`, `err_par`, `err_ovr`, `irq_rx` and `irq_err` are 0 and `rx_data` is 0.
- R2: A frame is a 0 start bit, then 8 data bits least significant first, then one extra bit when `par_en` or `mp_mode` is 1, then a stop bit. Each bit lasts 16 ticks. A character accepted with a stop bit of 1 is written to `rx_data`, and `rx_full` is set. `irq_rx` is high whenever `rx_full` is high.
- R3: A one-cycle `rd_ack` pulse clears `rx_full`, `err_frame`, `err_par` and `err_ovr`.
- R4: In plain mode with `par_en`=1, the extra bit is parity. With `par_odd`=0, the count of ones across the data and the parity bit must be even; with `par_odd`=1, it must be odd. On a mismatch, `err_par` is set, `rx_data` is left unchanged and `rx_full` is not set.
- R5: A stop bit sampled as 0 on a character that is not skipped sets `err_frame`, leaves `rx_data` unchanged and does not set `rx_full`. `irq_err` is high whenever any error flag is high.
- R6: If a good character completes while `rx_full` is set (and no `rd_ack` arrives in the same cycle), `err_ovr` is set and `rx_data` keeps the earlier character.
- R7: With `mp_mode`=1, an extra bit of 1 marks an address character and 0 marks a payload character. A payload character that arrives while the node is not addressed changes no output, even when its stop bit is 0.
- R8: An address character with a good stop bit that differs from `own_id` is not delivered, and the node becomes unaddressed. An address character with a stop bit of 0 sets `err_frame` and also leaves the node unaddressed.
- R9: An address character equal to `own_id` is delivered like data, and the node becomes addressed. It then delivers every following payload character until the next address character arrives.
- R10: With `mp_mode`=1, `par_en` and `par_odd` have no effect on delivery or on `err_par`.
- R11: A low pulse on `rxd` that is high again at the middle of the start bit does not start a character, and the receiver then looks for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Serial line, idles high |
| mp_mode | input | 1 | 1 selects addressed format |
| par_en | input | 1 | Parity bit present and checked (plain mode) |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| own_id | input | 8 | Node address compared with address characters |
| rd_ack | input | 1 | Host read strobe, clears full and error flags |
| rx_data | output | 8 | Last delivered character |
| rx_full | output | 1 | Holding register holds unread data |
| err_frame | output | 1 | Stop bit was 0 |
| err_par | output | 1 | Parity mismatch |
| err_ovr | output | 1 | Character lost because holding register was full |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The hardest state to reach is the interplay of the addressed/unaddressed state with errors. Examples are a payload character with a bad stop bit that must leave no trace while unaddressed, and an address character with a bad stop bit that must raise an error yet also drop the address match. The stimulus reaches these cases by sending, in order: payload before any address (including one whose value equals the node address), a foreign address, the matching address, payload with deliberately wrong parity, a second foreign address, and finally a matching address with a broken stop bit followed by payload. A behavioural model in the bench tracks the addressed state and every flag, and it is compared with the outputs on each clock outside the stop bit.

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          mp_mode,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [DW-1:0] own_id,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          err_frame,
  output logic          err_par,
  output logic          err_ovr,
  output logic          irq_rx,
  output logic          irq_err
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 3);
  localparam int SW = DW + 2;

  typedef enum logic [1:0] {IDLE, START, BITS} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nb;
  logic [SW-1:0] sh;
  logic          matched;

  wire          ext     = mp_mode | par_en;
  wire [BW-1:0] last    = ext ? BW'(DW + 1) : BW'(DW);
  wire          samp    = (st == BITS) && tick && (cnt == CW'(OSR - 1));
  wire          done    = samp && (nb == last);
  wire [DW-1:0] d       = ext ? sh[SW-2:1] : sh[SW-1:2];
  wire          xb      = sh[SW-1];
  wire          par_bad = (^{d, xb}) != par_odd;
  wire          is_id   = mp_mode & xb;
  wire          listen  = ~mp_mode | is_id | matched;
  wire          id_miss = is_id & (d != own_id);
  wire          take    = done & listen & rxd & ~(~mp_mode & par_en & par_bad) & ~id_miss;
  wire          fe_set  = done & listen & ~rxd;
  wire          pe_set  = done & ~mp_mode & par_en & rxd & par_bad;
  wire          full_eff = rx_full & ~rd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
      nb  <= '0;
      sh  <= '0;
    end else if (tick) begin
      case (st)
        IDLE: if (!rxd) begin
          st  <= START;
          cnt <= '0;
        end
        START: if (cnt == CW'(OSR / 2 - 1)) begin
          cnt <= '0;
          nb  <= '0;
          st  <= rxd ? IDLE : BITS;
        end else cnt <= cnt + 1'b1;
        BITS: if (cnt == CW'(OSR - 1)) begin
          cnt <= '0;
          sh  <= {rxd, sh[SW-1:1]};
          nb  <= nb + 1'b1;
          if (nb == last) st <= IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_full   <= 1'b0;
      err_frame <= 1'b0;
      err_par   <= 1'b0;
      err_ovr   <= 1'b0;
      matched   <= 1'b0;
    end else begin
      if (rd_ack) begin
        rx_full   <= 1'b0;
        err_frame <= 1'b0;
        err_par   <= 1'b0;
        err_ovr   <= 1'b0;
      end
      if (take) begin
        if (full_eff) err_ovr <= 1'b1;
        else begin
          rx_data <= d;
          rx_full <= 1'b1;
        end
      end
      if (fe_set) err_frame <= 1'b1;
      if (pe_set) err_par   <= 1'b1;
      if (!mp_mode) matched <= 1'b0;
      else if (done && is_id) matched <= rxd && (d == own_id);
    end
  end

  assign irq_rx  = rx_full;
  assign irq_err = err_frame | err_par | err_ovr;

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full && $past(!rx_full || rd_ack));
  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !done |=> !rx_full && !err_frame && !err_par && !err_ovr);
  // R6
  ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> $past(rx_full));
  // R10
  par_plain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_par) |-> $past(!mp_mode && par_en));
  // R5
  frame_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> $past(done));
  // R7
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mp_mode && !xb && !matched && !rd_ack |=>
      $stable({rx_data, rx_full, err_frame, err_par, err_ovr}));
endmodule

// File: tb/mpuart_rx_bench.sv
module mpuart_rx_bench;
  logic clk = 0, rst_n = 0, rxd = 1, mp = 0, pe_en = 0, podd = 0, rd_ack = 0;
  logic [7:0] oid = 8'h3C;
  logic [7:0] rx_data;
  logic rx_full, err_frame, err_par, err_ovr, irq_rx, irq_err;
  logic [1:0] tdiv = 0;
  wire tick = (tdiv == 2'd3);

  int nchk = 0, nfail = 0;
  bit cmp_en = 0;
  string cur_req = "R1";
  logic [7:0] m_data = 0;
  bit m_full = 0, m_fe = 0, m_pe = 0, m_ov = 0, m_match = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 1'b1;

  mpuart_rx u_mpuart_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mp_mode(mp),
    .par_en(pe_en), .par_odd(podd), .own_id(oid), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
    .err_par(err_par), .err_ovr(err_ovr), .irq_rx(irq_rx), .irq_err(irq_err));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (cmp_en && rst_n) begin
      chk(cur_req, "rx_full", rx_full, m_full);
      chk(cur_req, "rx_data", rx_data, m_data);
      chk("R5", "err_frame", err_frame, m_fe);
      chk("R4", "err_par", err_par, m_pe);
      chk("R6", "err_ovr", err_ovr, m_ov);
      chk("R2", "irq_rx", irq_rx, m_full);
      chk("R5", "irq_err", irq_err, m_fe | m_pe | m_ov);
    end
  end

  task automatic deliver(logic [7:0] d);
    if (m_full) m_ov = 1;
    else begin m_data = d; m_full = 1; end
  endtask

  task automatic model(logic [7:0] d, bit xb, bit stopv);
    if (mp) begin
      if (xb) begin
        if (!stopv) begin m_fe = 1; m_match = 0; end
        else if (d == oid) begin m_match = 1; deliver(d); end
        else m_match = 0;
      end else if (m_match) begin
        if (!stopv) m_fe = 1; else deliver(d);
      end
    end else if (!stopv) m_fe = 1;
    else if (pe_en && (((^d) ^ xb) != podd)) m_pe = 1;
    else deliver(d);
  endtask

  task automatic hold(bit v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] d, bit xb, bit stopv);
    @(negedge clk);
    cmp_en = 1;
    hold(0, 64);
    for (int i = 0; i < 8; i++) hold(d[i], 64);
    if (mp || pe_en) hold(xb, 64);
    cmp_en = 0;
    if (stopv) hold(1, 64);
    else begin hold(0, 40); hold(1, 24); end
    model(d, xb, stopv);
    cmp_en = 1;
    hold(1, 64);
  endtask

  task automatic rd;
    @(negedge clk);
    cmp_en = 0;
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    m_full = 0; m_fe = 0; m_pe = 0; m_ov = 0;
    cmp_en = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1", "rx_full", rx_full, 0);
    chk("R1", "rx_data", rx_data, 0);
    chk("R1", "errors", {err_frame, err_par, err_ovr}, 0);
    chk("R1", "irqs", {irq_rx, irq_err}, 0);
    rst_n = 1;
    repeat (8) @(negedge clk);

    // R2 plain character, no extra bit
    cur_req = "R2";
    frame(8'hA5, 0, 1);
    chk("R2", "data A5", rx_data, 8'hA5);
    // R3 read strobe clears
    cur_req = "R3";
    rd();
    chk("R3", "full cleared", rx_full, 0);

    // R4 parity even ok, odd ok, even bad
    cur_req = "R4";
    pe_en = 1; podd = 0;
    frame(8'h0F, 0, 1); rd();
    podd = 1;
    frame(8'h07, 0, 1);
    chk("R4", "odd accepted", rx_data, 8'h07);
    rd();
    podd = 0;
    frame(8'h01, 0, 1);
    chk("R4", "err_par set", err_par, 1);
    chk("R4", "data kept", rx_data, 8'h07);
    rd();

    // R5 framing error
    cur_req = "R5";
    pe_en = 0;
    frame(8'h55, 0, 0);
    chk("R5", "err_frame set", err_frame, 1);
    chk("R5", "not full", rx_full, 0);
    rd();

    // R6 overrun
    cur_req = "R6";
    frame(8'h11, 0, 1);
    frame(8'h22, 0, 1);
    chk("R6", "overrun", err_ovr, 1);
    chk("R6", "first kept", rx_data, 8'h11);
    rd();

    // R11 short start glitch
    cur_req = "R11";
    @(negedge clk);
    cmp_en = 1;
    hold(0, 16);
    hold(1, 160);
    chk("R11", "no char", rx_full, 0);
    frame(8'h33, 0, 1);
    chk("R11", "next char ok", rx_data, 8'h33);
    rd();

    // R7 payload before any address is dropped
    cur_req = "R7";
    mp = 1; pe_en = 1; podd = 0;
    frame(8'h3C, 0, 1);
    frame(8'h99, 0, 0);
    chk("R7", "skipped", {rx_full, err_frame}, 0);

    // R8 foreign address, then payload dropped
    cur_req = "R8";
    frame(8'h41, 1, 1);
    frame(8'h12, 0, 1);
    chk("R8", "nothing", rx_full, 0);

    // R9 own address delivered, payload follows
    cur_req = "R9";
    frame(8'h3C, 1, 1);
    chk("R9", "id delivered", rx_data, 8'h3C);
    rd();
    // R10 wrong parity ignored in addressed mode
    cur_req = "R10";
    frame(8'h80, 0, 1);
    chk("R10", "no err_par", err_par, 0);
    chk("R10", "payload delivered", rx_data, 8'h80);
    rd();
    cur_req = "R9";
    frame(8'h81, 0, 1);
    chk("R9", "payload 2", rx_data, 8'h81);
    rd();

    // R8 second foreign address ends the transfer
    cur_req = "R8";
    frame(8'h40, 1, 1);
    frame(8'h77, 0, 1);
    chk("R8", "dropped after miss", rx_full, 0);

    // R8 own address with bad stop bit
    frame(8'h3C, 1, 0);
    chk("R8", "id frame error", err_frame, 1);
    rd();
    cur_req = "R7";
    frame(8'h05, 0, 1);
    chk("R7", "not addressed", rx_full, 0);

    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule